// File: doc/BRIEF.md
# Latched 4-to-16 Line Decoder

This block turns a four-bit binary index into one active line out of sixteen. An input register captures the index on every system clock edge at which the strobe input is high. When strobe is low, the register keeps the last index it captured, so the index bus can change freely without disturbing the outputs. A downstream stage can use the decoded lines as one-hot selects or enables that stay put between strobe pulses.

An inhibit input forces all sixteen lines to their inactive level. It acts on the output stage only. The captured index is left alone, and it reappears on the lines as soon as inhibit drops. The parameter `ACTIVE_LOW` sets the output sense when the design is elaborated. With the default of 0 the chosen line is 1 and the others are 0. With 1 the chosen line is 0 and the others are 1.

Top module: `latched_line_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the held index to 0. Line 0 is then the active line.
- R2: With inhibit low, exactly one line is active. Its position equals the held index, with `sel[3]` as the most significant bit, so index 8 (`sel` = 4'b1000) drives line 8.
- R3: At every clock edge where `strobe` is 1, the held index takes the value of `sel`. The decoded lines show the new index right after that edge.
- R4: At a clock edge where `strobe` is 0, the held index does not change, whatever `sel` is doing.
- R5: After strobe falls, the lines keep showing the index captured at the last edge at which strobe was high.
- R6: While `inhibit` is 1, every line is at its inactive level. This takes effect in the same cycle, without waiting for a clock edge.
- R7: Inhibit leaves the held index unchanged. When inhibit returns to 0, the lines decode the held index again.
- R8: With inhibit high, a strobe edge still loads `sel`. That index shows up once inhibit is released.
- R9: With `ACTIVE_LOW` = 0, the active level is 1 and the inactive level is 0. With `ACTIVE_LOW` = 1 the levels are swapped, so inhibit drives all lines to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Capture enable for the index register |
| inhibit | input | 1 | Forces all lines inactive |
| sel | input | 4 | Binary index, bit 3 most significant |
| lines | output | 16 | Decoded outputs, sense chosen by ACTIVE_LOW |

## Verification
The bench checks that a change on `sel` with strobe low is not captured. A register enabled on the wrong level would show a new line here. It releases inhibit after a strobe edge that happened while inhibit was high. A design that stalls capture during inhibit would then come back with the old line. It also checks that inhibit acts before any clock edge, which catches an inhibit that was wrongly registered. It runs both output senses side by side and walks all sixteen indices, including the top bit alone, so a swapped bit order or a missing inversion is caught.

// File: rtl/latched_line_decoder.sv
module latched_line_decoder #(
  parameter int IDX_W      = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int LINES     = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             inhibit,
  input  logic [IDX_W-1:0] sel,
  output logic [LINES-1:0] lines
);

  logic [IDX_W-1:0] held_q;
  logic [LINES-1:0] hot;
  logic [LINES-1:0] gated;

  always_ff @(posedge clk) begin
    if (rst)
      held_q <= '0;
    else if (strobe)
      held_q <= sel;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_dec
    assign hot[i] = (held_q == IDX_W'(i));
  end

  assign gated = inhibit ? '0 : hot;

  if (ACTIVE_LOW) begin : g_low
    assign lines = ~gated;
  end else begin : g_high
    assign lines = gated;
  end

endmodule

// File: rtl/latched_line_decoder_chk.sv
module latched_line_decoder_chk #(
  parameter int IDX_W      = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int LINES     = 1 << IDX_W
) (
  input logic             clk,
  input logic             rst,
  input logic             strobe,
  input logic             inhibit,
  input logic [IDX_W-1:0] sel,
  input logic [LINES-1:0] lines
);

  logic [LINES-1:0] act;
  assign act = ACTIVE_LOW ? ~lines : lines;

  assert_reset_line0_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !inhibit) |-> (act == LINES'(1)));

  assert_single_active_R2: assert property (@(posedge clk) disable iff (rst)
    !inhibit |-> ($countones(act) == 1));

  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(strobe) && !inhibit) |-> (act == (LINES'(1) << $past(sel))));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(strobe) && !$past(inhibit) && !inhibit) |-> $stable(lines));

  assert_inhibit_R6: assert property (@(posedge clk) disable iff (rst)
    inhibit |-> (act == '0));

endmodule

bind latched_line_decoder latched_line_decoder_chk #(
  .IDX_W(IDX_W), .ACTIVE_LOW(ACTIVE_LOW)
) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .inhibit(inhibit), .sel(sel), .lines(lines)
);

// File: tb/latched_line_decoder_tb.sv
module latched_line_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  // vector: {strobe, inhibit, sel[3:0], exp_idx[3:0], exp_off}
  localparam logic [10:0] VECS [NVEC] = '{
    {1'b1, 1'b0, 4'd5,  4'd5,  1'b0},  // R3
    {1'b0, 1'b0, 4'd9,  4'd5,  1'b0},  // R4
    {1'b1, 1'b0, 4'd15, 4'd15, 1'b0},  // R3
    {1'b1, 1'b0, 4'd0,  4'd0,  1'b0},  // R3
    {1'b0, 1'b1, 4'd3,  4'd0,  1'b1},  // R6
    {1'b0, 1'b0, 4'd3,  4'd0,  1'b0},  // R7
    {1'b1, 1'b1, 4'd10, 4'd10, 1'b1},  // R8
    {1'b0, 1'b0, 4'd2,  4'd10, 1'b0},  // R8
    {1'b1, 1'b0, 4'd8,  4'd8,  1'b0},  // R2
    {1'b1, 1'b0, 4'd1,  4'd1,  1'b0},  // R3
    {1'b0, 1'b0, 4'd14, 4'd1,  1'b0}   // R5
  };

  logic clk = 1'b0;
  logic rst, strobe, inhibit;
  logic [3:0] sel;
  logic [15:0] lines_hi, lines_lo;
  int n_tests = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  latched_line_decoder #(.ACTIVE_LOW(1'b0)) u_dut (
    .clk(clk), .rst(rst), .strobe(strobe), .inhibit(inhibit), .sel(sel), .lines(lines_hi));
  latched_line_decoder #(.ACTIVE_LOW(1'b1)) u_dut_lo (
    .clk(clk), .rst(rst), .strobe(strobe), .inhibit(inhibit), .sel(sel), .lines(lines_lo));

  function automatic logic [15:0] expect_hi(input logic [3:0] idx, input logic off);
    return off ? 16'h0000 : (16'h0001 << idx);
  endfunction

  task automatic check(input string req, input logic [3:0] idx, input logic off);
    n_tests++;
    if (lines_hi !== expect_hi(idx, off)) begin
      n_fail++;
      $display("FAIL %s high-sense: got %h expected %h", req, lines_hi, expect_hi(idx, off));
    end
    n_tests++;
    if (lines_lo !== ~expect_hi(idx, off)) begin
      n_fail++;
      $display("FAIL %s low-sense R9: got %h expected %h", req, lines_lo, ~expect_hi(idx, off));
    end
  endtask

  task automatic step(input logic s, input logic inh, input logic [3:0] d);
    @(negedge clk);
    strobe = s; inhibit = inh; sel = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; strobe = 1'b0; inhibit = 1'b0; sel = 4'd7;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset", 4'd0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      step(VECS[v][10], VECS[v][9], VECS[v][8:5]);
      check($sformatf("R2-vector%0d", v), VECS[v][4:1], VECS[v][0]);
    end

    // R2: sweep all indices
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b0, 4'(i));
      check("R2 sweep", 4'(i), 1'b0);
    end

    // R6: inhibit acts before any clock edge
    @(negedge clk);
    strobe = 1'b0; inhibit = 1'b1;
    #1;
    check("R6 immediate", 4'd15, 1'b1);
    inhibit = 1'b0;
    #1;
    check("R7 release", 4'd15, 1'b0);

    // R4/R5: many sel changes with strobe low
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 4'(3 * i + 1));
      check("R4 hold", 4'd15, 1'b0);
    end

    // R1: reset in mid-operation
    step(1'b1, 1'b0, 4'd6);
    check("R3 load", 4'd6, 1'b0);
    @(negedge clk);
    rst = 1'b1; strobe = 1'b1; sel = 4'd12;
    @(posedge clk);
    #1;
    check("R1 mid reset", 4'd0, 1'b0);
    @(negedge clk);
    rst = 1'b0; strobe = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule